// File: doc/BRIEF.md
# Interrupting GPIO Bank on APB

A bank of up to 32 general-purpose pins controlled over an APB slave port. Each register bit maps to the pin of the same number. Incoming pad values pass through a two-flop synchronizer before software or the interrupt logic sees them. The output data, the direction, and every interrupt setting are changed only through paired write-one-to-set and write-one-to-clear addresses. A zero bit in a write leaves the matching pin alone, so drivers need no read-modify-write.

Each pin can raise an interrupt in one of two ways. In level mode the interrupt follows the pin at the selected polarity. In edge mode the pin latches on a rising edge, a falling edge, or any edge when the any-edge override is set. Software clears latched edges by writing ones to a clear address. The enabled status bits are ORed into one registered interrupt line. A loopback mode feeds the output data register into the synchronizer in place of the pads and turns every pad driver off, which lets the bank be tested without external wiring.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is an input (pad_oe = 0). pad_out is 0 and irq_o is 0. The enable, edge, polarity, any-edge and control readbacks are all 0.
- R2: A write of ones to word 0 (0x00) sets the matching output data bits. A write of ones to word 1 (0x04) clears them. Zero bits leave their outputs unchanged. pad_out shows the output data one cycle after the write.
- R3: Writing ones to 0x08 makes those pins drive (pad_oe bit = 1). Writing ones to 0x0C returns them to input. Zero bits have no effect.
- R4: Each pair of addresses reads back the same field. Interrupt enable is at 0x10/0x14, edge select (1 = edge) at 0x18/0x1C, polarity (1 = high/rising) at 0x20/0x24, and any-edge override at 0x28/0x2C. The lower address of each pair sets bits and the upper one clears them.
- R5: A read of 0x00 returns the pad levels after two clock edges of synchronization.
- R6: A pin in level mode reports status equal to its synchronized level when polarity is 1, and the inverse when polarity is 0. Writing to 0x30 does not change a level status. Status is read at 0x04, so after reset with all pads low it reads all ones.
- R7: A pin in edge mode latches its status on a rising edge when polarity is 1 and on a falling edge when polarity is 0. A pin that is not enabled never latches.
- R8: With the any-edge override set, an edge-mode pin latches on both edges, whatever its polarity. Writing ones to 0x30 clears the matching latched bits.
- R9: If an edge and a 0x30 clear hit the same pin in the same cycle, the status bit ends up set.
- R10: irq_o equals the OR of status ANDed with enable, delayed by one register.
- R11: With control bit 0 (0x34) set, the synchronizer samples the output data register instead of the pads, and pad_oe is held at 0. Clearing the bit restores pad_oe to the direction register.
- R12: Reads of 0x08, 0x0C, 0x30 and of unmapped words 0x38/0x3C return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 6 | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Output data to pads |
| pad_oe | output | NPINS | Pad output enables |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
An edge arriving at the latch and a software clear of the same pin can fall in one clock cycle. The bench provokes this by toggling the pad one cycle before the setup phase of a write to 0x30. With that offset, the synchronized rise reaches the latch on the same edge that the write completes. The bench reads status afterwards and expects the bit set. A plain clear with no edge must then leave it at 0. A second overlap, a level-mode pin receiving a clear, must leave the status unchanged.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  typedef logic [31:0] word_t;

  localparam int NUM_PAIRS = 6;

  localparam logic [3:0] IDX_STATE   = 4'd0;
  localparam logic [3:0] IDX_STATUS  = 4'd1;
  localparam logic [3:0] IDX_DIR_OUT = 4'd2;
  localparam logic [3:0] IDX_DIR_IN  = 4'd3;
  localparam logic [3:0] IDX_EN_S    = 4'd4;
  localparam logic [3:0] IDX_EN_C    = 4'd5;
  localparam logic [3:0] IDX_EDG_S   = 4'd6;
  localparam logic [3:0] IDX_EDG_C   = 4'd7;
  localparam logic [3:0] IDX_POL_S   = 4'd8;
  localparam logic [3:0] IDX_POL_C   = 4'd9;
  localparam logic [3:0] IDX_ANY_S   = 4'd10;
  localparam logic [3:0] IDX_ANY_C   = 4'd11;
  localparam logic [3:0] IDX_ICLR    = 4'd12;
  localparam logic [3:0] IDX_CTRL    = 4'd13;

  function automatic word_t f_pair_next(word_t cur, word_t setm, word_t clrm);
    return (cur | setm) & ~clrm;
  endfunction

  function automatic word_t f_trigger(word_t rise, word_t fall, word_t pol, word_t anyv);
    return (anyv & (rise | fall)) | (~anyv & ((pol & rise) | (~pol & fall)));
  endfunction

  function automatic word_t f_level(word_t lvl, word_t pol);
    return ~(lvl ^ pol);
  endfunction

  function automatic word_t f_latch_next(word_t cur, word_t hit, word_t clr);
    return (cur & ~clr) | hit;
  endfunction
endpackage

// File: rtl/gpb_pair.sv
module gpb_pair
  import gpb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t set_m,
  input  word_t clr_m,
  output word_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= f_pair_next(q, set_m, clr_m);
  end
endmodule

// File: rtl/gpb_sync.sv
module gpb_sync
  import gpb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  loop_en,
  input  word_t pad_w,
  input  word_t dout,
  output word_t state
);
  word_t src, s1_q, s2_q;

  assign src = loop_en ? dout : pad_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= src;
      s2_q <= s1_q;
    end
  end

  assign state = s2_q;
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
  import gpb_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_idx,
  input  word_t      wdata,
  input  logic [3:0] rd_idx,
  input  word_t      state,
  input  word_t      status,
  output word_t      dout,
  output word_t      dir,
  output word_t      en,
  output word_t      edge_cfg,
  output word_t      pol,
  output word_t      anyv,
  output word_t      iclr,
  output logic       loop_en,
  output word_t      rdata
);
  localparam word_t PIN_MASK = word_t'((64'd1 << NPINS) - 64'd1);

  word_t wmask;
  word_t fld [NUM_PAIRS];
  logic  ctrl_q;

  assign wmask = wdata & PIN_MASK;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    word_t s_m, c_m;
    assign s_m = (wr_en && wr_idx == 4'(2 * g))     ? wmask : '0;
    assign c_m = (wr_en && wr_idx == 4'(2 * g + 1)) ? wmask : '0;
    gpb_pair u_pair (
      .clk   (clk),
      .rst_n (rst_n),
      .set_m (s_m),
      .clr_m (c_m),
      .q     (fld[g])
    );
  end

  assign dout     = fld[0];
  assign dir      = fld[1];
  assign en       = fld[2];
  assign edge_cfg = fld[3];
  assign pol      = fld[4];
  assign anyv     = fld[5];

  assign iclr = (wr_en && wr_idx == IDX_ICLR) ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ctrl_q <= 1'b0;
    else if (wr_en && wr_idx == IDX_CTRL) ctrl_q <= wdata[0];
  end

  assign loop_en = ctrl_q;

  always_comb begin
    case (rd_idx)
      IDX_STATE:           rdata = state;
      IDX_STATUS:          rdata = status;
      IDX_EN_S, IDX_EN_C:   rdata = en;
      IDX_EDG_S, IDX_EDG_C: rdata = edge_cfg;
      IDX_POL_S, IDX_POL_C: rdata = pol;
      IDX_ANY_S, IDX_ANY_C: rdata = anyv;
      IDX_CTRL:            rdata = {31'b0, ctrl_q};
      default:             rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpb_irq.sv
module gpb_irq
  import gpb_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t state,
  input  word_t en,
  input  word_t edge_cfg,
  input  word_t pol,
  input  word_t anyv,
  input  word_t iclr,
  output word_t status,
  output word_t hit,
  output word_t latch,
  output logic  irq_q
);
  localparam word_t PIN_MASK = word_t'((64'd1 << NPINS) - 64'd1);

  word_t prev_q, latch_q, rise, fall, trig;

  assign rise = state & ~prev_q;
  assign fall = ~state & prev_q;
  assign trig = f_trigger(rise, fall, pol, anyv);
  assign hit  = trig & en & edge_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      prev_q  <= state;
      latch_q <= f_latch_next(latch_q, hit, iclr);
      irq_q   <= |(status & en);
    end
  end

  assign status = ((edge_cfg & latch_q) | (~edge_cfg & f_level(state, pol))) & PIN_MASK;
  assign latch  = latch_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpb_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 6
) (
  input  logic             pclk,
  input  logic             presetn,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq_o
);
  localparam int IW = 4;

  logic          apb_wr;
  logic [IW-1:0] widx;
  logic          wr_dout;
  logic          wr_dir_set;
  logic          wr_iclr;
  word_t dout, dir, en, edge_cfg, pol, anyv, iclr, state, status, hit, latch, pad_w;
  logic  loop_en;

  assign apb_wr     = psel & penable & pwrite;
  assign widx       = paddr[AW-1:2];
  assign wr_dout    = apb_wr && (widx == IDX_STATE || widx == IDX_STATUS);
  assign wr_dir_set = apb_wr && (widx == IDX_DIR_OUT);
  assign wr_iclr    = apb_wr && (widx == IDX_ICLR);
  assign pad_w      = word_t'(pad_in);

  gpb_regs #(.NPINS(NPINS)) u_regs (
    .clk(pclk), .rst_n(presetn), .wr_en(apb_wr), .wr_idx(widx), .wdata(pwdata),
    .rd_idx(widx), .state(state), .status(status), .dout(dout), .dir(dir), .en(en),
    .edge_cfg(edge_cfg), .pol(pol), .anyv(anyv), .iclr(iclr), .loop_en(loop_en),
    .rdata(prdata)
  );

  gpb_sync u_sync (
    .clk(pclk), .rst_n(presetn), .loop_en(loop_en), .pad_w(pad_w), .dout(dout),
    .state(state)
  );

  gpb_irq #(.NPINS(NPINS)) u_irq (
    .clk(pclk), .rst_n(presetn), .state(state), .en(en), .edge_cfg(edge_cfg),
    .pol(pol), .anyv(anyv), .iclr(iclr), .status(status), .hit(hit),
    .latch(latch), .irq_q(irq_o)
  );

  assign pad_out = dout[NPINS-1:0];
  assign pad_oe  = loop_en ? '0 : dir[NPINS-1:0];
endmodule

// File: rtl/gpb_chk.sv
module gpb_chk
  import gpb_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_dout,
  input logic             wr_dir_set,
  input logic             wr_iclr,
  input logic [31:0]      pwdata,
  input word_t            dir,
  input word_t            hit,
  input word_t            latch,
  input word_t            status,
  input word_t            en,
  input logic             loop_en,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq_o
);
  localparam word_t PIN_MASK = word_t'((64'd1 << NPINS) - 64'd1);

  a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dout |=> $stable(pad_out));

  a_r3_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_set |=> ((dir & $past(pwdata & PIN_MASK)) == $past(pwdata & PIN_MASK)));

  a_r8_clear_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wr_iclr |=> ((latch & $past(pwdata & PIN_MASK & ~hit)) == '0));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch & $past(hit)) == $past(hit)));

  a_r10_irq_reg: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(status & en))));

  a_r11_loop_oe: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (pad_oe == '0));
endmodule

bind gpio_bank gpb_chk #(.NPINS(NPINS)) u_chk (
  .clk(pclk), .rst_n(presetn), .wr_dout(wr_dout), .wr_dir_set(wr_dir_set),
  .wr_iclr(wr_iclr), .pwdata(pwdata), .dir(dir), .hit(hit), .latch(latch),
  .status(status), .en(en), .loop_en(loop_en), .pad_out(pad_out),
  .pad_oe(pad_oe), .irq_o(irq_o)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
  localparam int NP = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [5:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_bank #(.NPINS(NP), .AW(6)) u0 (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] d, acc, pat;
    logic [31:0] pats [4];
    pats[0] = 32'hA5A5_0F0F; pats[1] = 32'h0000_0001; pats[2] = 32'h8000_0000; pats[3] = 32'h3C96_E11B;

    idle(3); rst_n = 1; idle(2);

    // R1 reset state
    check("R1 pad_oe", 32'(pad_oe), 0);
    check("R1 pad_out", 32'(pad_out), 0);
    check("R1 irq", 32'(irq_o), 0);
    for (int a = 16; a <= 52; a += 4) begin
      if (a != 48) begin rd(6'(a), d); check("R1 cfg readback", d, 0); end
    end

    // R2 set/clear of output data
    acc = 0;
    for (int i = 0; i < 4; i++) begin
      wr(6'h00, pats[i]); acc = acc | pats[i];
      check("R2 set out", 32'(pad_out), acc);
      wr(6'h04, pats[(i + 1) % 4]); acc = acc & ~pats[(i + 1) % 4];
      check("R2 clr out", 32'(pad_out), acc);
    end
    wr(6'h00, 0); check("R2 zero write", 32'(pad_out), acc);

    // R3 direction
    wr(6'h08, 32'hF0F0_1234); check("R3 dir out", 32'(pad_oe), 32'hF0F0_1234);
    wr(6'h0C, 32'h1000_0034); check("R3 dir in", 32'(pad_oe), 32'hE0F0_1200);
    wr(6'h08, 0);             check("R3 zero write", 32'(pad_oe), 32'hE0F0_1200);

    // R12 write-only and unmapped reads
    rd(6'h08, d); check("R12 rd 0x08", d, 0);
    rd(6'h0C, d); check("R12 rd 0x0C", d, 0);
    rd(6'h30, d); check("R12 rd 0x30", d, 0);
    rd(6'h38, d); check("R12 rd 0x38", d, 0);
    rd(6'h3C, d); check("R12 rd 0x3C", d, 0);

    // R4 paired configuration registers
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 4; i++) begin
        wr(6'(16 + 8 * p), pats[i]);
        wr(6'(20 + 8 * p), pats[(i + 2) % 4]);
        pat = pats[i] & ~pats[(i + 2) % 4];
        rd(6'(16 + 8 * p), d); check("R4 set addr", d, pat);
        rd(6'(20 + 8 * p), d); check("R4 clr addr", d, pat);
        wr(6'(20 + 8 * p), 32'hFFFF_FFFF);
      end
    end

    // R5 synchronized input
    for (int i = 0; i < 4; i++) begin
      pad_in = pats[i]; idle(1);
      rd(6'h00, d); check("R5 state", d, pats[i]);
    end

    // R6 level mode (edge cfg all 0), polarity H, enable all
    wr(6'h10, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) begin
      wr(6'h24, 32'hFFFF_FFFF); wr(6'h20, pats[(i + 1) % 4]);
      pad_in = pats[i]; idle(3);
      pat = ~(pats[i] ^ pats[(i + 1) % 4]);
      rd(6'h04, d); check("R6 level status", d, pat);
      wr(6'h30, 32'hFFFF_FFFF);
      rd(6'h04, d); check("R6 clear ignored", d, pat);
      check("R10 irq level", 32'(irq_o), 32'(|pat));
    end
    wr(6'h14, 32'hFFFF_FFFF); idle(2);
    check("R10 irq masked", 32'(irq_o), 0);

    // R7/R8 edge modes: m=0 rise, m=1 fall, m=2 any-edge
    wr(6'h18, 32'hFFFF_FFFF);
    for (int m = 0; m < 3; m++) begin
      for (int i = 0; i < 4; i++) begin
        logic [31:0] en_m;
        en_m = pats[(i + 3) % 4] | 32'h0000_FFFF;
        wr(6'h14, 32'hFFFF_FFFF); wr(6'h10, en_m);
        wr(6'h24, 32'hFFFF_FFFF); wr(6'h2C, 32'hFFFF_FFFF);
        if (m == 0) wr(6'h20, 32'hFFFF_FFFF);
        if (m == 2) wr(6'h28, 32'hFFFF_FFFF);
        pad_in = 0; idle(4); wr(6'h30, 32'hFFFF_FFFF);
        rd(6'h04, d); check("R8 cleared", d, 0);
        pad_in = pats[i]; idle(4);
        rd(6'h04, d);
        check(m == 2 ? "R8 any rise" : "R7 rise", d, (m != 1) ? (pats[i] & en_m) : 0);
        check("R10 irq edge", 32'(irq_o), 32'(|((m != 1) ? (pats[i] & en_m) : 0)));
        wr(6'h30, 32'hFFFF_FFFF);
        pad_in = 0; idle(4);
        rd(6'h04, d);
        check(m == 2 ? "R8 any fall" : "R7 fall", d, (m != 0) ? (pats[i] & en_m) : 0);
      end
    end

    // R9 edge and clear in the same cycle on pin 0 (rising, enabled)
    wr(6'h2C, 32'hFFFF_FFFF); wr(6'h20, 1); wr(6'h10, 1);
    pad_in = 0; idle(4); wr(6'h30, 32'hFFFF_FFFF);
    @(negedge clk); pad_in[0] = 1'b1;
    @(negedge clk); psel = 1; pwrite = 1; paddr = 6'h30; pwdata = 1; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    rd(6'h04, d); check("R9 set wins", d & 1, 1);
    wr(6'h30, 1);
    rd(6'h04, d); check("R9 plain clear", d & 1, 0);

    // R11 loopback
    wr(6'h14, 32'hFFFF_FFFF);
    wr(6'h08, 32'hFFFF_FFFF);
    pad_in = 32'h1234_5678;
    wr(6'h34, 1);
    check("R11 oe held low", 32'(pad_oe), 0);
    wr(6'h04, 32'hFFFF_FFFF); wr(6'h00, 32'hC0DE_0A55); idle(3);
    rd(6'h00, d); check("R11 loop state", d, 32'hC0DE_0A55);
    rd(6'h34, d); check("R11 ctrl readback", d, 1);
    wr(6'h34, 0);
    check("R11 oe restored", 32'(pad_oe), 32'hFFFF_FFFF);
    idle(3);
    rd(6'h00, d); check("R11 pads again", d, 32'h1234_5678);

    done = 1;
    summary();
  end
endmodule